// File: doc/BRIEF.md
# Fixed-Field Instruction Decoder

This block takes one 32-bit instruction word per strobe and turns it into a registered bundle of control fields for a small register-based core. The word is cut into five fixed slices: an 8-bit opcode, a 6-bit extension, and three 6-bit operand slices. The opcode picks an instruction class: arithmetic/logic, move, no-operation, jump, call/return, or system stop/restart. Within one opcode, the extension selects the variant. Depending on the class, that variant is an immediate versus register second source, unsigned arithmetic, the transfer direction of a move, or a branch condition code.

Register specifiers cover a 36-entry namespace. Values 0 to 31 are the general registers. Values 32 to 35 are four special registers: general pointer, data pointer, instruction pointer and flags. Any specifier the bundle routes out above 35 raises a range error. An opcode outside the defined set raises `illegal_op` and forces every other control output to zero.

The bundle appears one clock after the strobe and is qualified by `out_valid`. It holds its value while no new word arrives. Execution, register storage and memory accesses belong to downstream stages.

Top module: `insn_field_decoder`

## Requirements
- R1: The word is sliced as opcode = bits [7:0], extension e = bits [13:8], operand a = bits [19:14], operand b = bits [25:20], operand c = bits [31:26].
- R2: A word presented with `in_valid` high produces its decoded bundle and `out_valid`=1 after the next rising clock edge. A cycle with `in_valid` low gives `out_valid`=0 and leaves every other output unchanged.
- R3: While reset is asserted, all outputs are zero. Reset takes effect immediately, without waiting for a clock edge.
- R4: `insn_class` is set from the opcode as follows: 0–7 give 1 (ALU, with `alu_fn` = opcode: add, sub, mul, div, and, or, shift-left, shift-right); 8 gives 2 (move); 9 gives 3 (no-op); 0x0A gives 4 (jump); 0x0C gives 5 (call/return); 0x7F gives 6 (system).
- R5: Any other opcode, including all values of 0x80 and above, gives `illegal_op`=1 with every other control output, including `reg_range_err`, at zero.
- R6: For ALU opcodes, `dst_reg` = a and `src1_reg` = b. When e bit 0 is 0, `src2_reg` = c and `src2_imm`=0. When e bit 0 is 1, `src2_imm`=1 and `src2_reg`=0.
- R7: `unsigned_op` = e bit 1 for add and sub (opcodes 0, 1) and is 0 for every other opcode.
- R8: For a move, `addr_mode` = a[1:0]. e=2 is a load (`mov_dir`=1, `dst_reg`=b, `src1_reg`=c). e=0 is a store (`mov_dir`=2, `src1_reg`=b, `src2_reg`=c as base). e=1 is an immediate move (`mov_dir`=3, `dst_reg`=c, `src2_imm`=1). Any other e gives `mov_dir`=0 and zero registers. Outside moves, `addr_mode` and `mov_dir` are 0.
- R9: For a jump, `cond_code` = e. When e[5:4] = 0 (register-compare form), `src1_reg` = a and `src2_reg` = b. Otherwise (flag-test form), both are 0. Outside jumps, `cond_code` is 0.
- R10: `ctl_op` is 1 for CALL (opcode 0x0C, e=3), 2 for RET (0x0C, e=0), 3 for HALT (0x7F, e=0) and 4 for RESET (0x7F, e=1). It is 0 for every other combination.
- R11: `reg_range_err`=1 exactly when one of `dst_reg`, `src1_reg`, `src2_reg` is above 35.
- R12: A no-op drives all register, flag, mode and code outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word strobe |
| in_word | input | 32 | Instruction word |
| out_valid | output | 1 | Bundle updated this cycle |
| illegal_op | output | 1 | Opcode outside the defined set |
| insn_class | output | 3 | Instruction class code |
| alu_fn | output | 3 | ALU function |
| src2_imm | output | 1 | Second source is an immediate |
| unsigned_op | output | 1 | Unsigned add/sub |
| ctl_op | output | 3 | Call/return/halt/reset code |
| mov_dir | output | 2 | Move direction |
| addr_mode | output | 2 | Move addressing mode |
| cond_code | output | 6 | Jump condition code |
| dst_reg | output | 6 | Destination register |
| src1_reg | output | 6 | First source register |
| src2_reg | output | 6 | Second source or base register |
| reg_range_err | output | 1 | A routed specifier exceeds the namespace |

## Verification
The decoder keeps no state beyond its output register and the reset synchronizer. A wrong decode therefore shows on the ports in the cycle after the offending strobe, with nothing delayed further.

A captured bundle that changes while the strobe is low, or that is cleared late or only partly under reset, is visible within one cycle. So is a register field routed to the wrong role. Illegal opcodes that leak control values, and unsigned or immediate flags raised under the wrong opcode, appear on the very next valid output.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

  parameter int WORD_W = 32;
  parameter int OPC_W  = 8;
  parameter int EXT_W  = 6;
  parameter int REG_W  = 6;
  parameter int CLS_W  = 3;

  localparam int OPC_LSB = 0;
  localparam int EXT_LSB = OPC_LSB + OPC_W;
  localparam int FA_LSB  = EXT_LSB + EXT_W;
  localparam int FB_LSB  = FA_LSB + REG_W;
  localparam int FC_LSB  = FB_LSB + REG_W;

  localparam logic [OPC_W-1:0] OPC_MOV  = OPC_W'(8'h08);
  localparam logic [OPC_W-1:0] OPC_NOP  = OPC_W'(8'h09);
  localparam logic [OPC_W-1:0] OPC_JMP  = OPC_W'(8'h0A);
  localparam logic [OPC_W-1:0] OPC_CALL = OPC_W'(8'h0C);
  localparam logic [OPC_W-1:0] OPC_SYS  = OPC_W'(8'h7F);
  localparam int               NUM_ALU  = 8;

  typedef enum logic [CLS_W-1:0] {
    CLS_NONE    = 3'd0,
    CLS_ALU     = 3'd1,
    CLS_MOVE    = 3'd2,
    CLS_NOP     = 3'd3,
    CLS_BRANCH  = 3'd4,
    CLS_CALLRET = 3'd5,
    CLS_SYSTEM  = 3'd6
  } cls_e;

  typedef enum logic [2:0] {
    CTL_NONE  = 3'd0,
    CTL_CALL  = 3'd1,
    CTL_RET   = 3'd2,
    CTL_HALT  = 3'd3,
    CTL_RESET = 3'd4
  } ctl_e;

  typedef enum logic [1:0] {
    MV_NONE  = 2'd0,
    MV_LOAD  = 2'd1,
    MV_STORE = 2'd2,
    MV_IMM   = 2'd3
  } mvdir_e;

  typedef struct packed {
    logic [REG_W-1:0] fc;
    logic [REG_W-1:0] fb;
    logic [REG_W-1:0] fa;
    logic [EXT_W-1:0] ext;
    logic [OPC_W-1:0] opc;
  } fields_t;

  typedef struct packed {
    logic             illegal;
    cls_e             cls;
    logic [2:0]       alu_fn;
    logic             src2_imm;
    logic             uns;
    ctl_e             ctl;
    mvdir_e           mdir;
    logic [1:0]       amode;
    logic [EXT_W-1:0] cond;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src1;
    logic [REG_W-1:0] src2;
    logic             rng_err;
  } bundle_t;

endpackage

// File: rtl/ifd_split.sv
module ifd_split
  import ifd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output fields_t           flds
);

  localparam int USED_W = FC_LSB + REG_W;

  generate
    if (USED_W == WORD_W) begin : g_exact
      always_comb begin
        flds.opc = word[OPC_LSB +: OPC_W];
        flds.ext = word[EXT_LSB +: EXT_W];
        flds.fa  = word[FA_LSB  +: REG_W];
        flds.fb  = word[FB_LSB  +: REG_W];
        flds.fc  = word[FC_LSB  +: REG_W];
      end
    end else begin : g_bad_layout
      initial $error("field widths do not fill the instruction word");
      assign flds = '0;
    end
  endgenerate

endmodule

// File: rtl/ifd_classify.sv
module ifd_classify
  import ifd_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output cls_e             cls,
  output logic             legal
);

  always_comb begin
    cls   = CLS_NONE;
    legal = 1'b1;
    if (int'(opc) < NUM_ALU) begin
      cls = CLS_ALU;
    end else begin
      case (opc)
        OPC_MOV:  cls = CLS_MOVE;
        OPC_NOP:  cls = CLS_NOP;
        OPC_JMP:  cls = CLS_BRANCH;
        OPC_CALL: cls = CLS_CALLRET;
        OPC_SYS:  cls = CLS_SYSTEM;
        default: begin
          cls   = CLS_NONE;
          legal = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/ifd_operands.sv
module ifd_operands
  import ifd_pkg::*;
(
  input  fields_t flds,
  input  cls_e    cls,
  output bundle_t dec
);

  localparam logic [EXT_W-1:0] E0 = EXT_W'(0);
  localparam logic [EXT_W-1:0] E1 = EXT_W'(1);
  localparam logic [EXT_W-1:0] E2 = EXT_W'(2);
  localparam logic [EXT_W-1:0] E3 = EXT_W'(3);

  logic addsub;
  assign addsub = (flds.opc[2:1] == 2'b00);

  always_comb begin
    dec = '0;
    dec.illegal = 1'b0;
    dec.cls     = cls;
    dec.ctl     = CTL_NONE;
    dec.mdir    = MV_NONE;
    case (cls)
      CLS_ALU: begin
        dec.alu_fn = flds.opc[2:0];
        dec.dst    = flds.fa;
        dec.src1   = flds.fb;
        if (flds.ext[0]) begin
          dec.src2_imm = 1'b1;
        end else begin
          dec.src2 = flds.fc;
        end
        dec.uns = addsub & flds.ext[1];
      end
      CLS_MOVE: begin
        dec.amode = flds.fa[1:0];
        case (flds.ext)
          E2: begin
            dec.mdir = MV_LOAD;
            dec.dst  = flds.fb;
            dec.src1 = flds.fc;
          end
          E0: begin
            dec.mdir = MV_STORE;
            dec.src1 = flds.fb;
            dec.src2 = flds.fc;
          end
          E1: begin
            dec.mdir     = MV_IMM;
            dec.dst      = flds.fc;
            dec.src2_imm = 1'b1;
          end
          default: dec.mdir = MV_NONE;
        endcase
      end
      CLS_BRANCH: begin
        dec.cond = flds.ext;
        if (flds.ext[5:4] == 2'b00) begin
          dec.src1 = flds.fa;
          dec.src2 = flds.fb;
        end
      end
      CLS_CALLRET: begin
        if (flds.ext == E3)      dec.ctl = CTL_CALL;
        else if (flds.ext == E0) dec.ctl = CTL_RET;
      end
      CLS_SYSTEM: begin
        if (flds.ext == E0)      dec.ctl = CTL_HALT;
        else if (flds.ext == E1) dec.ctl = CTL_RESET;
      end
      default: dec.cls = cls;
    endcase
  end

endmodule

// File: rtl/insn_field_decoder.sv
module insn_field_decoder
  import ifd_pkg::*;
#(
  parameter int NUM_REGS = 36,
  parameter int N_ROLES  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [WORD_W-1:0]   in_word,
  output logic                out_valid,
  output logic                illegal_op,
  output logic [CLS_W-1:0]    insn_class,
  output logic [2:0]          alu_fn,
  output logic                src2_imm,
  output logic                unsigned_op,
  output logic [2:0]          ctl_op,
  output logic [1:0]          mov_dir,
  output logic [1:0]          addr_mode,
  output logic [EXT_W-1:0]    cond_code,
  output logic [REG_W-1:0]    dst_reg,
  output logic [REG_W-1:0]    src1_reg,
  output logic [REG_W-1:0]    src2_reg,
  output logic                reg_range_err
);

  localparam logic [REG_W:0] REG_LIMIT = (REG_W+1)'(NUM_REGS);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_q = rst_pipe[1];

  fields_t flds;
  cls_e    cls;
  logic    legal;
  bundle_t raw;
  bundle_t nxt;
  bundle_t cur;
  logic    vld_q;

  ifd_split    u_split    (.word(in_word), .flds(flds));
  ifd_classify u_classify (.opc(flds.opc), .cls(cls), .legal(legal));
  ifd_operands u_operands (.flds(flds), .cls(cls), .dec(raw));

  // range check over each routed register role
  logic [REG_W-1:0]   roles [N_ROLES];
  logic [N_ROLES-1:0] over;

  assign roles[0] = raw.dst;
  assign roles[1] = raw.src1;
  assign roles[2] = raw.src2;

  generate
    for (genvar g = 0; g < N_ROLES; g++) begin : g_range
      assign over[g] = ({1'b0, roles[g]} >= REG_LIMIT);
    end
  endgenerate

  // next-state: suppress everything on an illegal opcode
  always_comb begin
    if (!legal) begin
      nxt         = '0;
      nxt.cls     = CLS_NONE;
      nxt.ctl     = CTL_NONE;
      nxt.mdir    = MV_NONE;
      nxt.illegal = 1'b1;
    end else begin
      nxt         = raw;
      nxt.rng_err = |over;
    end
  end

  // output register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      vld_q <= 1'b0;
      cur   <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) cur <= nxt;
    end
  end

  assign out_valid     = vld_q;
  assign illegal_op    = cur.illegal;
  assign insn_class    = cur.cls;
  assign alu_fn        = cur.alu_fn;
  assign src2_imm      = cur.src2_imm;
  assign unsigned_op   = cur.uns;
  assign ctl_op        = cur.ctl;
  assign mov_dir       = cur.mdir;
  assign addr_mode     = cur.amode;
  assign cond_code     = cur.cond;
  assign dst_reg       = cur.dst;
  assign src1_reg      = cur.src1;
  assign src2_reg      = cur.src2;
  assign reg_range_err = cur.rng_err;

endmodule

// File: rtl/ifd_chk.sv
module ifd_chk
  import ifd_pkg::*;
#(
  parameter int NUM_REGS = 36
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [WORD_W-1:0]   in_word,
  input logic                out_valid,
  input logic                illegal_op,
  input logic [CLS_W-1:0]    insn_class,
  input logic [2:0]          alu_fn,
  input logic                src2_imm,
  input logic                unsigned_op,
  input logic [2:0]          ctl_op,
  input logic [1:0]          mov_dir,
  input logic [1:0]          addr_mode,
  input logic [EXT_W-1:0]    cond_code,
  input logic [REG_W-1:0]    dst_reg,
  input logic [REG_W-1:0]    src1_reg,
  input logic [REG_W-1:0]    src2_reg,
  input logic                reg_range_err
);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(insn_class) && $stable(dst_reg) &&
                   $stable(src1_reg) && $stable(src2_reg) && $stable(cond_code) &&
                   $stable(illegal_op) && $stable(ctl_op) && $stable(addr_mode)));

  // R5
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> (insn_class == '0 && alu_fn == '0 && !src2_imm && !unsigned_op &&
                    ctl_op == '0 && mov_dir == '0 && addr_mode == '0 &&
                    cond_code == '0 && dst_reg == '0 && src1_reg == '0 &&
                    src2_reg == '0 && !reg_range_err));

  // R6
  imm_no_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src2_imm && insn_class == CLS_ALU) |-> src2_reg == '0);

  // R7
  unsigned_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unsigned_op |-> (insn_class == CLS_ALU && alu_fn <= 3'd1));

  // R8
  movdir_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mov_dir != '0) |-> insn_class == CLS_MOVE);

  // R9
  cond_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_code != '0) |-> insn_class == CLS_BRANCH);

  // R11
  range_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_range_err |-> (int'(dst_reg) >= NUM_REGS || int'(src1_reg) >= NUM_REGS ||
                       int'(src2_reg) >= NUM_REGS));

  // R12
  nop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word[7:0] == 8'h09) |=>
      (insn_class == CLS_NOP && dst_reg == '0 && src1_reg == '0 && src2_reg == '0));

endmodule

bind insn_field_decoder ifd_chk #(.NUM_REGS(NUM_REGS)) i_ifd_chk (.rst_n(rst_n_q), .*);

// File: tb/test_insn_field_decoder.sv
`timescale 1ns/1ps
module test_insn_field_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_word;
  logic        out_valid, illegal_op, src2_imm, unsigned_op, reg_range_err;
  logic [2:0]  insn_class, alu_fn, ctl_op;
  logic [1:0]  mov_dir, addr_mode;
  logic [5:0]  cond_code, dst_reg, src1_reg, src2_reg;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  insn_field_decoder i_insn_field_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .illegal_op(illegal_op), .insn_class(insn_class),
    .alu_fn(alu_fn), .src2_imm(src2_imm), .unsigned_op(unsigned_op),
    .ctl_op(ctl_op), .mov_dir(mov_dir), .addr_mode(addr_mode),
    .cond_code(cond_code), .dst_reg(dst_reg), .src1_reg(src1_reg),
    .src2_reg(src2_reg), .reg_range_err(reg_range_err)
  );

  // vector: {tag[4], word[32], expected[41]}
  function automatic logic [76:0] v(
    input int tag, input int c, input int b, input int a, input int e, input int op,
    input int ill, input int cls, input int fn, input int imm, input int uns,
    input int ctl, input int md, input int am, input int cc,
    input int d, input int s1, input int s2, input int err);
    return {4'(tag), 6'(c), 6'(b), 6'(a), 6'(e), 8'(op),
            1'(ill), 3'(cls), 3'(fn), 1'(imm), 1'(uns), 3'(ctl), 2'(md), 2'(am),
            6'(cc), 6'(d), 6'(s1), 6'(s2), 1'(err)};
  endfunction

  localparam int NV = 24;
  localparam logic [76:0] VEC [NV] = '{
    v( 1,  2, 1, 3, 0,   0, 0,1,0,0,0,0,0,0, 0, 3, 1, 2,0), // R1 R4 R6 add reg
    v( 6,  7, 5, 4, 1,   0, 0,1,0,1,0,0,0,0, 0, 4, 5, 0,0), // R6 add imm
    v( 7,  9, 8, 6, 2,   0, 0,1,0,0,1,0,0,0, 0, 6, 8, 9,0), // R7 unsigned add
    v( 7,  0,10,11, 3,   1, 0,1,1,1,1,0,0,0, 0,11,10, 0,0), // R7 unsigned sub imm
    v( 7,  3, 2, 1, 2,   2, 0,1,2,0,0,0,0,0, 0, 1, 2, 3,0), // R7 mul ignores e[1]
    v( 4,  0,33,35, 1,   7, 0,1,7,1,0,0,0,0, 0,35,33, 0,0), // R4 shr special regs
    v(11, 40, 1, 2, 0,   4, 0,1,4,0,0,0,0,0, 0, 2, 1,40,1), // R11 and, bad c
    v( 8, 34, 5, 2, 2,   8, 0,2,0,0,0,0,1,2, 0, 5,34, 0,0), // R8 load
    v( 8, 12, 7, 3, 0,   8, 0,2,0,0,0,0,2,3, 0, 0, 7,12,0), // R8 store
    v( 8, 20, 0, 0, 1,   8, 0,2,0,1,0,0,3,0, 0,20, 0, 0,0), // R8 imm move
    v( 8, 20, 4, 1, 5,   8, 0,2,0,0,0,0,0,1, 0, 0, 0, 0,0), // R8 unknown e
    v(12,  5, 6, 7, 0,   9, 0,3,0,0,0,0,0,0, 0, 0, 0, 0,0), // R12 nop
    v( 9,  0,14,13, 0,  10, 0,4,0,0,0,0,0,0, 0, 0,13,14,0), // R9 compare eq
    v( 9,  0,14,13,52,  10, 0,4,0,0,0,0,0,0,52, 0, 0, 0,0), // R9 flag test
    v(11,  0,50, 2, 2,  10, 0,4,0,0,0,0,0,0, 2, 0, 2,50,1), // R11 branch bad b
    v(10,  0, 0, 0, 3,  12, 0,5,0,0,0,1,0,0, 0, 0, 0, 0,0), // R10 call
    v(10,  0, 0, 9, 0,  12, 0,5,0,0,0,2,0,0, 0, 0, 0, 0,0), // R10 ret
    v(10,  0, 0, 0, 1,  12, 0,5,0,0,0,0,0,0, 0, 0, 0, 0,0), // R10 undefined e
    v(10,  0, 0, 0, 0, 127, 0,6,0,0,0,3,0,0, 0, 0, 0, 0,0), // R10 halt
    v(10,  0, 0, 0, 1, 127, 0,6,0,0,0,4,0,0, 0, 0, 0, 0,0), // R10 reset
    v(10,  0, 0, 0, 2, 127, 0,6,0,0,0,0,0,0, 0, 0, 0, 0,0), // R10 undefined e
    v( 5,  1, 2, 3, 1,  11, 1,0,0,0,0,0,0,0, 0, 0, 0, 0,0), // R5 hole at 0x0B
    v( 5,  0, 0, 0, 0, 136, 1,0,0,0,0,0,0,0, 0, 0, 0, 0,0), // R5 0x88
    v( 5, 63,63,63,63, 255, 1,0,0,0,0,0,0,0, 0, 0, 0, 0,0)  // R5 0xFF
  };

  function automatic logic [40:0] got();
    return {illegal_op, insn_class, alu_fn, src2_imm, unsigned_op, ctl_op,
            mov_dir, addr_mode, cond_code, dst_reg, src1_reg, src2_reg, reg_range_err};
  endfunction

  task automatic check(input string req, input logic [40:0] act, input logic [40:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
      end
    end
  end

  initial begin
    logic [40:0] held;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_word  = '0;
    repeat (3) @(negedge clk);
    // R3 reset state
    check("R3", {out_valid, got()}, 42'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      in_word  = VEC[i][72:41];
      in_valid = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b1) begin
        fails++;
        $display("FAIL R2: vector %0d out_valid got %b expected 1", i, out_valid);
      end
      check($sformatf("R%0d vector %0d", VEC[i][76:73], i), got(), VEC[i][40:0]);
    end

    // R2 hold while strobe low, new word ignored
    in_word  = VEC[6][72:41];
    in_valid = 1'b1;
    @(negedge clk);
    held     = got();
    in_valid = 1'b0;
    in_word  = VEC[11][72:41];
    @(negedge clk);
    check("R2 out_valid low", {40'd0, out_valid}, 41'd0);
    check("R2 hold", got(), held);
    @(negedge clk);
    check("R2 hold second cycle", got(), VEC[6][40:0]);

    // R3 asynchronous clear mid-run
    in_word  = VEC[0][72:41];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    #1 rst_n = 1'b0;
    #0.5;
    check("R3 async clear", {out_valid, got()} >> 1, 41'd0);
    check("R3 async clear valid", {40'd0, out_valid}, 41'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R3 state after release, strobe still low
    check("R3 after release", got(), 41'd0);

    summary();
  end

endmodule